// File: doc/BRIEF.md
# Two-Bit-Per-Step SAR Sequencer

This block is the digital controller for a single successive-approximation conversion channel. It turns one start request into a 7-bit result in five clock cycles. In cycle 1 it samples the input. In cycle 2 a voltage comparator gives the most significant bit on its own. In each of cycles 3, 4 and 5 it resolves two bits. The higher bit of each pair comes from the polarity decision of the voltage comparator. The lower bit comes from a time comparator that is clocked a little later, and that comparator tells whether the residue magnitude has reached a finer threshold.

Around the block sit the sampling switch and the output-reset switch. Three strobes launch the delayed time-comparator clocks, one per paired step. Six intermediate nodes of a capacitive DAC take three-level drive codes from the sequencer. A node rests at mid level. It is pushed high or low by a decision, and it floats once the next pair of nodes has been applied. The sixth node stays at mid level and is kept for calibration. The finished code is registered and marked by a one-cycle done pulse.

Top module: `sar2b_seq`

## Requirements
- R1: When `start` is high in an idle cycle, the next cycle is conversion cycle 1. In that cycle alone, `sample_en` and `out_reset` are both high.
- R2: In cycles 1 and 2, and in every idle cycle, all six node codes are mid (2'b10) and `tstrobe` is 3'b000.
- R3: `tstrobe` is 3'b001 in cycle 3, 3'b010 in cycle 4 and 3'b100 in cycle 5. At most one strobe bit is ever high.
- R4: `result[6]` is the `vcmp` value taken at the end of cycle 2. In cycle 3, node A (`node_drv[1:0]`) is high (2'b11) if that bit is 1 and low (2'b01) if it is 0.
- R5: At the end of cycles 3, 4 and 5, `vcmp` sets the higher bit of the pair (result bits 5, 3, 1). The lower bit (result bits 4, 2, 0) equals `tcmp` when `vcmp` is 1 and `~tcmp` when `vcmp` is 0.
- R6: In cycle 4, node A floats (2'b00), node B (`[3:2]`) follows result bit 5 and node C (`[5:4]`) follows result bit 4. In cycle 5, nodes A, B and C float, node D (`[7:6]`) follows bit 3 and node E (`[9:8]`) follows bit 2. A bit of 1 drives high and a bit of 0 drives low.
- R7: Node F (`[11:10]`) is mid in every cycle. In the cycle after cycle 5, every node is back at mid.
- R8: `done` is high for exactly one cycle, the cycle after cycle 5. In that cycle `result` holds the new code, and it keeps that code until the next done.
- R9: A `start` that arrives during cycles 1 to 5 is ignored. The running conversion finishes unchanged and no new sample phase follows it.
- R10: `tcmp` has no effect during cycles 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request |
| vcmp | input | 1 | Voltage comparator polarity decision |
| tcmp | input | 1 | Time comparator magnitude decision |
| sample_en | output | 1 | Input sampling switch enable |
| out_reset | output | 1 | DAC output node reset switch |
| tstrobe | output | 3 | Launch strobes for delayed time-comparator clocks 1..3 |
| node_drv | output | 12 | Two-bit drive code per node A..F (00 float, 01 low, 10 mid, 11 high) |
| result | output | 7 | Converted code, MSB in bit 6 |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
A wrong step counter shows up at the ports within one cycle. The strobe pattern, the sampling pulse or the node codes then fall out of their fixed order, or the done pulse arrives early or late. A corrupted captured bit shows up one cycle later as a wrong drive code on the node that carries it, and it also shows up in the registered result. A wrong conversion of the magnitude into a binary bit appears only in the lower bit of a pair. For that reason the comparator decisions are chosen from targeted and random codes that cover both polarities.

// File: rtl/sar2b_seq.sv
module sar2b_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        vcmp,
  input  logic        tcmp,
  output logic        sample_en,
  output logic        out_reset,
  output logic [2:0]  tstrobe,
  output logic [11:0] node_drv,
  output logic [6:0]  result,
  output logic        done
);

  localparam logic [1:0] FLT = 2'b00;
  localparam logic [1:0] LO  = 2'b01;
  localparam logic [1:0] MID = 2'b10;
  localparam logic [1:0] HI  = 2'b11;

  logic [2:0] step;
  logic [6:0] bits;
  logic       mag;

  assign mag = ~(vcmp ^ tcmp);

  function automatic logic [1:0] lvl(input logic b);
    return b ? HI : LO;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step   <= 3'd0;
      bits   <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= (step == 3'd5);
      case (step)
        3'd0: if (start) step <= 3'd1;
        3'd1: step <= 3'd2;
        3'd2: begin bits[6] <= vcmp; step <= 3'd3; end
        3'd3: begin bits[5] <= vcmp; bits[4] <= mag; step <= 3'd4; end
        3'd4: begin bits[3] <= vcmp; bits[2] <= mag; step <= 3'd5; end
        3'd5: begin
          bits[1] <= vcmp;
          bits[0] <= mag;
          result  <= {bits[6:2], vcmp, mag};
          step    <= 3'd0;
        end
        default: step <= 3'd0;
      endcase
    end
  end

  assign sample_en = (step == 3'd1);
  assign out_reset = (step == 3'd1);
  assign tstrobe   = {step == 3'd5, step == 3'd4, step == 3'd3};

  always_comb begin
    node_drv = {6{MID}};
    case (step)
      3'd3: node_drv[1:0] = lvl(bits[6]);
      3'd4: begin
        node_drv[1:0] = FLT;
        node_drv[3:2] = lvl(bits[5]);
        node_drv[5:4] = lvl(bits[4]);
      end
      3'd5: begin
        node_drv[5:0] = {3{FLT}};
        node_drv[7:6] = lvl(bits[3]);
        node_drv[9:8] = lvl(bits[2]);
      end
      default: ;
    endcase
  end

  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tstrobe));

  // R3
  strobe_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tstrobe[0] |=> tstrobe[1]);

  // R1
  sample_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> (!sample_en && tstrobe == 3'b000));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(tstrobe[2]));

  // R7
  node_f_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tstrobe[2] |=> (node_drv == {6{MID}}));

endmodule

// File: tb/sar2b_seq_tb.sv
module sar2b_seq_tb_top;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic vcmp = 1'b0;
  logic tcmp = 1'b0;
  logic sample_en, out_reset, done;
  logic [2:0] tstrobe;
  logic [11:0] node_drv;
  logic [6:0] result;

  int checks = 0;
  int fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  sar2b_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vcmp(vcmp), .tcmp(tcmp),
    .sample_en(sample_en), .out_reset(out_reset), .tstrobe(tstrobe),
    .node_drv(node_drv), .result(result), .done(done)
  );

  function automatic logic [1:0] nd(input logic b);
    return b ? 2'b11 : 2'b01;
  endfunction

  function automatic logic tsel(input logic hi, input logic lo);
    return hi ? lo : ~lo;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic convert(input logic [6:0] t, input bit busy_start);
    logic [11:0] exp;
    @(negedge clk);
    start = 1'b1; vcmp = 1'($urandom); tcmp = 1'($urandom);
    @(negedge clk);
    start = 1'b0;
    chk("R1 sample_en", sample_en, 1);
    chk("R1 out_reset", out_reset, 1);
    chk("R2 nodes c1", node_drv, 12'hAAA);
    chk("R2 strobe c1", tstrobe, 0);
    vcmp = t[6]; tcmp = 1'($urandom);
    @(negedge clk);
    chk("R1 sample_en c2", sample_en, 0);
    chk("R2 nodes c2", node_drv, 12'hAAA);
    chk("R2 strobe c2", tstrobe, 0);
    tcmp = ~tcmp;
    @(negedge clk);
    exp = 12'hAAA; exp[1:0] = nd(t[6]);
    chk("R3 strobe c3", tstrobe, 3'b001);
    chk("R4 node A", node_drv, exp);
    vcmp = t[5]; tcmp = tsel(t[5], t[4]);
    if (busy_start) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    exp = 12'hAAA; exp[1:0] = 2'b00; exp[3:2] = nd(t[5]); exp[5:4] = nd(t[4]);
    chk("R3 strobe c4", tstrobe, 3'b010);
    chk("R6 nodes c4", node_drv, exp);
    vcmp = t[3]; tcmp = tsel(t[3], t[2]);
    @(negedge clk);
    exp = 12'hAAA; exp[5:0] = 6'b0; exp[7:6] = nd(t[3]); exp[9:8] = nd(t[2]);
    chk("R3 strobe c5", tstrobe, 3'b100);
    chk("R6 nodes c5", node_drv, exp);
    vcmp = t[1]; tcmp = tsel(t[1], t[0]);
    @(negedge clk);
    chk("R8 done", done, 1);
    chk("R5 R10 result", result, t);
    chk("R7 nodes mid", node_drv, 12'hAAA);
    chk("R9 no restart", sample_en, 0);
    vcmp = 1'($urandom); tcmp = 1'($urandom);
    @(negedge clk);
    chk("R8 done low", done, 0);
    chk("R8 result held", result, t);
    chk("R9 idle", sample_en, 0);
  endtask

  initial begin
    #(CLK_NS * 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R2 reset nodes", node_drv, 12'hAAA);
    chk("R8 reset done", done, 0);
    chk("R8 reset result", result, 0);
    chk("R1 reset sample", sample_en, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 idle strobe", tstrobe, 0);
    chk("R1 idle no sample", sample_en, 0);
    convert(7'h00, 1'b0);
    convert(7'h7F, 1'b0);
    convert(7'h55, 1'b1);
    convert(7'h2A, 1'b0);
    convert(7'h40, 1'b1);
    convert(7'h01, 1'b0);
    for (int i = 0; i < 40; i++) convert(7'($urandom), 1'($urandom));
    finish_run();
  end
endmodule